// File: doc/BRIEF.md
# Raster Beam Position Counter

This block keeps the horizontal and vertical raster position that beam-synchronized logic compares against. A horizontal counter advances on every color-clock enable and wraps at the end of each line. A vertical counter advances at each line wrap and wraps at the end of each field. The block outputs the counts, flags that tell whether the current line and the current field are long, a horizontal-blank indication, and one-clock strobes for start of line, start of frame and vertical blank.

Two timing standards are selected by `pal_i`. In the 60 Hz standard, line lengths alternate between 227 and 228 color clocks. In the 50 Hz standard, every line has 227 color clocks. With `lace_i` set, fields alternate between a short field and a long field that has one more line. In the 60 Hz standard, the line alternation runs on across field boundaries. The last line of each field therefore follows a pattern that repeats every four fields.

Top module: `beam_pos_counter`

## Requirements
- R1: While `rst_ni` is low, `hcount_o` and `vcount_o` are 0, `long_line_o` and `long_field_o` are 0, and `sol_o`, `sof_o` and `vblank_o` are 0. Counting starts on a short line in a short field.
- R2: The horizontal count advances by exactly one on each clock where `ce_i` is 1. It holds its value on clocks where `ce_i` is 0.
- R3: With `pal_i`=0, line lengths alternate between 227 and 228 enabled clocks, and `long_line_o`=1 marks a 228-count line. With `pal_i`=1, every line has 227 counts and `long_line_o` stays 0.
- R4: `hcount_o` never exceeds 0xE2. On a long line, the 228th count is reported as 0xE2, so 0xE2 is shown for two enabled counts.
- R5: `hblank_o` is 1 exactly when `hcount_o` is in the range 0x0F to 0x35 inclusive, which is 39 counts per line.
- R6: `sol_o` is high for exactly one clock, in the clock that follows the enabled edge at which the horizontal count wraps to 0.
- R7: With `lace_i`=0, a field has `V_NTSC` lines (default 262) when `pal_i`=0 and `V_PAL` lines (default 312) when `pal_i`=1. In this mode `long_field_o` stays 0.
- R8: With `lace_i`=1, fields alternate between short and long, starting short after reset. A long field has one extra line, and `long_field_o`=1 marks it.
- R9: With `pal_i`=0 and `lace_i`=1, the last line of each field follows this pattern from reset: long, short, short, long. The pattern then repeats.
- R10: `vcmp_o` always equals the low 8 bits of `vcount_o`, so lines 256 and above appear as 0 onward.
- R11: `sof_o` and `vblank_o` pulse together for one clock when the vertical count wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Color-clock enable |
| pal_i | input | 1 | 1 selects 50 Hz timing, 0 selects 60 Hz timing |
| lace_i | input | 1 | Interlace enable |
| hcount_o | output | 8 | Reported horizontal count |
| vcount_o | output | 9 | Vertical line count |
| vcmp_o | output | 8 | Low 8 bits of the vertical count |
| long_line_o | output | 1 | Current line is a 228-count line |
| long_field_o | output | 1 | Current field is a long field |
| hblank_o | output | 1 | Horizontal blanking range |
| sol_o | output | 1 | Start-of-line strobe |
| sof_o | output | 1 | Start-of-frame strobe |
| vblank_o | output | 1 | Vertical-blank strobe |

## Verification
The hardest condition to reach is the four-field interlace pattern. It only shows after thousands of lines, and it depends on the line parity running on across field boundaries. The bench therefore overrides the field lengths to 14 and 18 lines so that whole field sequences fit in the run time. It then records the length of the last line and the long-field flag of each field. The extra count on a long line, which is reported as 0xE2, is reached by watching the second line after reset. Single-clock strobes are checked with a sparse enable that leaves the count at 0 over several clocks.

// File: rtl/beam_pkg.sv
package beam_pkg;
  localparam int unsigned HW = 8;
  localparam int unsigned VW = 9;
  localparam int unsigned H_SHORT_DEF = 227;
  localparam int unsigned HB_FIRST = 8'h0F;
  localparam int unsigned HB_LAST  = 8'h35;
endpackage

// File: rtl/beam_hcnt.sv
module beam_hcnt #(
  parameter int unsigned H_SHORT = 227,
  parameter int unsigned HW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          pal_i,
  output logic [HW-1:0] h_o,
  output logic          long_line_o,
  output logic          line_end_o,
  output logic          sol_o
);
  localparam logic [HW-1:0] LastShort = HW'(H_SHORT - 1);
  localparam logic [HW-1:0] LastLong  = HW'(H_SHORT);

  logic [HW-1:0] h_q;
  logic          long_q;
  logic          sol_q;

  assign line_end_o = ce_i && (h_q >= (long_q ? LastLong : LastShort));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q    <= '0;
      long_q <= 1'b0;
      sol_q  <= 1'b0;
    end else begin
      sol_q <= line_end_o;
      if (ce_i) begin
        if (line_end_o) begin
          h_q    <= '0;
          long_q <= !pal_i && !long_q;
        end else begin
          h_q <= h_q + HW'(1);
        end
      end
    end
  end

  assign h_o         = h_q;
  assign long_line_o = long_q;
  assign sol_o       = sol_q;

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_i && !line_end_o |=> h_q == $past(h_q) + HW'(1));
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(h_q));
  assert_alt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o && !pal_i |=> long_q != $past(long_q));
  assert_pal_short_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o && pal_i |=> !long_q);
  assert_sol_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_q |-> h_q == '0);
  assert_sol_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_q |=> !sol_q);
endmodule

// File: rtl/beam_vcnt.sv
module beam_vcnt #(
  parameter int unsigned V_NTSC = 262,
  parameter int unsigned V_PAL  = 312,
  parameter int unsigned VW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic          pal_i,
  input  logic          lace_i,
  output logic [VW-1:0] v_o,
  output logic          long_field_o,
  output logic          sof_o,
  output logic          vblank_o
);
  localparam logic [VW-1:0] LastNtsc = VW'(V_NTSC - 1);
  localparam logic [VW-1:0] LastPal  = VW'(V_PAL - 1);

  logic [VW-1:0] v_q;
  logic [VW-1:0] v_last;
  logic          lf_q;
  logic          sof_q;
  logic          vbl_q;
  logic          frame_end;

  assign v_last    = (pal_i ? LastPal : LastNtsc) + VW'(lf_q);
  assign frame_end = line_end_i && (v_q >= v_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= '0;
      lf_q  <= 1'b0;
      sof_q <= 1'b0;
      vbl_q <= 1'b0;
    end else begin
      sof_q <= frame_end;
      vbl_q <= frame_end;
      if (line_end_i) begin
        if (frame_end) begin
          v_q  <= '0;
          lf_q <= lace_i && !lf_q;
        end else begin
          v_q <= v_q + VW'(1);
        end
      end
    end
  end

  assign v_o          = v_q;
  assign long_field_o = lf_q;
  assign sof_o        = sof_q;
  assign vblank_o     = vbl_q;

  assert_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q <= VW'(V_PAL));
  assert_lace_alt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && lace_i |=> lf_q != $past(lf_q));
  assert_prog_short_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end && !lace_i |=> !lf_q);
  assert_sof_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_q |-> v_q == '0);
  assert_sof_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_q |=> !sof_q);
endmodule

// File: rtl/beam_pos_counter.sv
module beam_pos_counter
  import beam_pkg::*;
#(
  parameter int unsigned H_SHORT = H_SHORT_DEF,
  parameter int unsigned V_NTSC  = 262,
  parameter int unsigned V_PAL   = 312
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          pal_i,
  input  logic          lace_i,
  output logic [HW-1:0] hcount_o,
  output logic [VW-1:0] vcount_o,
  output logic [7:0]    vcmp_o,
  output logic          long_line_o,
  output logic          long_field_o,
  output logic          hblank_o,
  output logic          sol_o,
  output logic          sof_o,
  output logic          vblank_o
);
  localparam logic [HW-1:0] HReportMax = HW'(H_SHORT - 1);
  localparam logic [HW-1:0] HbFirst    = HW'(HB_FIRST);
  localparam logic [HW-1:0] HbLast     = HW'(HB_LAST);

  logic [HW-1:0] h_raw;
  logic          line_end;

  beam_hcnt #(.H_SHORT(H_SHORT), .HW(HW)) u_hcnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce_i),
    .pal_i       (pal_i),
    .h_o         (h_raw),
    .long_line_o (long_line_o),
    .line_end_o  (line_end),
    .sol_o       (sol_o)
  );

  beam_vcnt #(.V_NTSC(V_NTSC), .V_PAL(V_PAL), .VW(VW)) u_vcnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_end_i   (line_end),
    .pal_i        (pal_i),
    .lace_i       (lace_i),
    .v_o          (vcount_o),
    .long_field_o (long_field_o),
    .sof_o        (sof_o),
    .vblank_o     (vblank_o)
  );

  // extra count of a long line is shown as the last short-line value
  assign hcount_o = (h_raw > HReportMax) ? HReportMax : h_raw;
  assign hblank_o = (hcount_o >= HbFirst) && (hcount_o <= HbLast);
  assign vcmp_o   = vcount_o[7:0];

  assert_report_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hcount_o <= HReportMax);
  assert_frame_line_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> sol_o);
endmodule

// File: tb/beam_pos_counter_bench.sv
`timescale 1ns/1ps
module beam_pos_counter_bench;
  localparam int NL = 14;
  localparam int PL = 18;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_i = 1'b0;
  logic pal_i = 1'b0;
  logic lace_i = 1'b0;
  logic [7:0] hcount_o;
  logic [8:0] vcount_o;
  logic [7:0] vcmp_o;
  logic long_line_o, long_field_o, hblank_o, sol_o, sof_o, vblank_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  beam_pos_counter #(.V_NTSC(NL), .V_PAL(PL)) u_beam_pos_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_i(ce_i), .pal_i(pal_i), .lace_i(lace_i),
    .hcount_o(hcount_o), .vcount_o(vcount_o), .vcmp_o(vcmp_o),
    .long_line_o(long_line_o), .long_field_o(long_field_o), .hblank_o(hblank_o),
    .sol_o(sol_o), .sof_o(sof_o), .vblank_o(vblank_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic pal, logic lace);
    ce_i = 1'b0; pal_i = pal; lace_i = lace; rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
  endtask

  task automatic wait_sof();
    do tick(); while (!sof_o);
  endtask

  // starts at a sof cycle, ends at the next one
  task automatic run_field(output int nlines, output int last_long, output int lfield,
                           output int bad_len, output int bad_alt, output int bad_misc);
    int len;
    int have_prev;
    logic prev_long, pl;
    nlines = 0; bad_len = 0; bad_alt = 0; bad_misc = 0; len = 0; have_prev = 0;
    last_long = 0; pl = 1'b0;
    lfield = int'(long_field_o);
    do begin
      prev_long = long_line_o;
      if (vcmp_o != vcount_o[7:0] || vblank_o != sof_o) bad_misc++;
      tick(); len++;
      if (sol_o) begin
        nlines++;
        if (len != (prev_long ? 228 : 227)) bad_len++;
        if (pal_i && prev_long) bad_alt++;
        if (!pal_i && have_prev != 0 && pl == prev_long) bad_alt++;
        pl = prev_long; have_prev = 1;
        last_long = int'(prev_long);
        len = 0;
      end
    end while (!sof_o);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    rst_ni = 1'b0; tick();
    chk("R1 hcount", hcount_o, 0);
    chk("R1 vcount", vcount_o, 0);
    chk("R1 long_line", long_line_o, 0);
    chk("R1 long_field", long_field_o, 0);
    chk("R1 strobes", {sol_o, sof_o, vblank_o}, 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_gaps();
    int seen;
    do_reset(1'b0, 1'b0);
    repeat (4) tick();
    chk("R2 hold without enable", hcount_o, 0);
    ce_i = 1'b1;
    repeat (10) tick();
    chk("R2 ten steps", hcount_o, 10);
    seen = 0;
    for (int i = 0; i < 1000 && seen == 0; i++) begin
      ce_i = (i % 2 == 0);
      tick();
      if (sol_o) begin
        seen = 1;
        ce_i = 1'b0;
        tick();
        chk("R6 sol width", sol_o, 0);
        chk("R2 hold at zero", hcount_o, 0);
      end
    end
    chk("R6 sol seen", seen, 1);
    ce_i = 1'b0;
  endtask

  task automatic t_hshape();
    int mx, n_e2, n_hb, hb_bad, ll;
    do_reset(1'b0, 1'b0);
    ce_i = 1'b1;
    do tick(); while (!sol_o);
    ll = int'(long_line_o);
    chk("R3 second line long", ll, 1);
    mx = 0; n_e2 = 0; n_hb = 0; hb_bad = 0;
    do begin
      if (hcount_o > mx) mx = hcount_o;
      if (hcount_o == 8'hE2) n_e2++;
      if (hblank_o) n_hb++;
      if (hblank_o != (hcount_o >= 8'h0F && hcount_o <= 8'h35)) hb_bad++;
      tick();
    end while (!sol_o);
    chk("R4 max reported", mx, 226);
    chk("R4 0xE2 counts on long line", n_e2, 2);
    chk("R5 hblank count", n_hb, 39);
    chk("R5 hblank range", hb_bad, 0);
  endtask

  task automatic t_prog(logic pal);
    int nl, lastl, lf, bl, ba, bm;
    do_reset(pal, 1'b0);
    ce_i = 1'b1;
    wait_sof();
    for (int f = 0; f < 2; f++) begin
      run_field(nl, lastl, lf, bl, ba, bm);
      chk("R7 lines per field", nl, pal ? PL : NL);
      chk("R7 long_field low", lf, 0);
      chk("R3 line lengths", bl, 0);
      chk("R3 alternation", ba, 0);
      chk("R10 R11 vcmp and vblank", bm, 0);
    end
  endtask

  task automatic t_lace(logic pal);
    int nl, lastl, lf, bl, ba, bm;
    int exp_last[4] = '{1, 0, 0, 1};
    do_reset(pal, 1'b1);
    ce_i = 1'b1;
    // first field runs from reset: short field
    wait_sof();
    chk("R8 first field short", long_field_o, 1);
    for (int f = 0; f < 4; f++) begin
      run_field(nl, lastl, lf, bl, ba, bm);
      chk("R8 field lines", nl, (pal ? PL : NL) + ((f % 2 == 0) ? 1 : 0));
      chk("R8 long_field", lf, (f % 2 == 0) ? 1 : 0);
      chk("R3 line lengths", bl, 0);
      chk("R10 R11 vcmp and vblank", bm, 0);
      if (!pal) chk("R9 last line of field", lastl, exp_last[(f + 1) % 4]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_gaps();
    t_hshape();
    t_prog(1'b0);
    t_prog(1'b1);
    t_lace(1'b0);
    t_lace(1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule